// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two N-bit unsigned words with one full adder that is used once per clock, starting at the least significant bit. Two right-shifting registers hold the operands. The accumulator register takes each new sum bit at its most significant end. The addend register feeds its low bit to the adder and refills from its own low bit or from a serial data pin. A carry flip-flop links one bit to the next. After N shift cycles the accumulator holds the sum modulo 2^N and the carry flip-flop holds bit N.

To use it, load the two registers in parallel while the block is idle, then pulse `start`. The block is busy for exactly N cycles and then raises `done` for one cycle. The accumulator keeps the running total, so the block can sum a list of values. Before each new start, either load a new addend in parallel or stream it in serially during the previous pass. If the addend recirculates, it comes back unchanged after N shifts and can be added again. The clock runs freely at all times. Only the shift enable derived from `busy` gates the datapath.

Top module: `serial_acc_adder`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the addend and the carry clear to 0, and `busy` and `done` go low.
- R2: While idle, `load_a` writes `a_in` into the accumulator at the next edge, and `load_b` writes `b_in` into the addend. A lone `load_b` leaves `result` and `carry_out` unchanged.
- R3: A `start` accepted while idle raises `busy` at the next edge. `busy` stays high for exactly N cycles. In the cycle after the last shift, `done` is high for exactly one cycle and `busy` is low.
- R4: When `done` is high, `result` equals the low N bits of the accumulator plus the addend as they were at the start of the pass, and `carry_out` equals bit N of that sum.
- R5: With `b_src` = 0 the addend rotates right through itself and is unchanged after a pass. Repeated starts without a load therefore add the same addend to the running total each time.
- R6: An accepted start clears the carry flip-flop, so a carry left over from an earlier pass never enters the new sum.
- R7: While `busy` is high, `load_a`, `load_b` and `start` have no effect on the sum being formed or on the number of shift cycles.
- R8: With `b_src` = 1 during a pass, `ser_in` enters the top of the addend on each shift cycle. The bit applied in the k-th shift cycle (k counted from 0) ends up in addend bit k, which then serves as the next operand.
- R9: A load and a start in the same idle cycle both take effect. The pass that follows uses the newly loaded values.
- R10: `carry_out` keeps its value after `done` until the next accepted start. A start in the same cycle that `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_a | input | 1 | Parallel load of the accumulator while idle |
| a_in | input | N | Parallel accumulator value |
| load_b | input | 1 | Parallel load of the addend while idle |
| b_in | input | N | Parallel addend value |
| b_src | input | 1 | Addend refill: 0 recirculate, 1 serial pin |
| ser_in | input | 1 | Serial addend bit, least significant first |
| start | input | 1 | Begin an N-cycle pass when idle |
| busy | output | 1 | High during the N shift cycles |
| done | output | 1 | One-cycle pulse after the final shift |
| result | output | N | Accumulator contents |
| carry_out | output | 1 | Carry flip-flop, final carry after a pass |

## Verification
Two sets of events can fall in the same cycle. The first is a parallel load with a start. The second is the completion pulse of one pass with the start of the next. The scoreboard driver raises load and start together at one idle edge and expects the sum to use the new operands. It also issues each following start at the very negedge where `done` is visible, with no idle gap. A shift count of exactly N per pass and the correct running total then show that neither event hid the other. Loads and starts thrown in during a pass show, through the scoreboarded totals, that they were ignored.

// File: rtl/serial_acc_pkg.sv
package serial_acc_pkg;

    // Operation applied to a shift register in one cycle
    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_LOAD  = 2'd1,
        SH_SHIFT = 2'd2
    } shift_op_e;

    // Output pair of a single-bit full adder
    typedef struct packed {
        logic cout;
        logic sum;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic x, input logic y, input logic cin);
        fa_out_t r;
        r.sum  = x ^ y ^ cin;
        r.cout = (x & y) | (x & cin) | (y & cin);
        return r;
    endfunction

    function automatic shift_op_e pick_op(input logic shifting, input logic load);
        if (shifting)
            return SH_SHIFT;
        else if (load)
            return SH_LOAD;
        else
            return SH_HOLD;
    endfunction

endpackage

// File: rtl/sacc_bit_adder.sv
module sacc_bit_adder
    import serial_acc_pkg::*;
(
    input  logic    x,
    input  logic    y,
    input  logic    cin,
    output fa_out_t fo
);
    always_comb fo = full_add(x, y, cin);
endmodule

// File: rtl/sacc_shift_reg.sv
module sacc_shift_reg
    import serial_acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  shift_op_e    op,
    input  logic [W-1:0] par_in,
    input  logic         top_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (op)
                SH_LOAD:  q <= par_in;
                SH_SHIFT: q <= {top_in, q[W-1:1]};
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/sacc_ctrl.sv
module sacc_ctrl #(
    parameter int N = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(N);
    localparam logic [CW-1:0] CNT_LAST = CW'(1);

    logic [CW-1:0] cnt_q;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            cnt_q <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    cnt_q <= CNT_FULL;
                end
            end else begin
                cnt_q <= cnt_q - CNT_LAST;
                if (cnt_q == CNT_LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R3
    busy_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt_q == CNT_FULL));
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R7
    run_continues_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != CNT_LAST) |=> (busy && cnt_q == $past(cnt_q) - CNT_LAST));
endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder
    import serial_acc_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_a,
    input  logic [N-1:0] a_in,
    input  logic         load_b,
    input  logic [N-1:0] b_in,
    input  logic         b_src,
    input  logic         ser_in,
    input  logic         start,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] result,
    output logic         carry_out
);
    logic         accept;
    logic [N-1:0] acc_q;
    logic [N-1:0] addend_q;
    logic         carry_q;
    fa_out_t      fa;
    shift_op_e    acc_op;
    shift_op_e    add_op;
    logic         add_top;

    sacc_ctrl #(.N(N)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .busy   (busy),
        .done   (done)
    );

    sacc_bit_adder u_fa (
        .x   (acc_q[0]),
        .y   (addend_q[0]),
        .cin (carry_q),
        .fo  (fa)
    );

    always_comb begin
        acc_op  = pick_op(busy, load_a);
        add_op  = pick_op(busy, load_b);
        add_top = b_src ? ser_in : addend_q[0];
    end

    sacc_shift_reg #(.W(N)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .op     (acc_op),
        .par_in (a_in),
        .top_in (fa.sum),
        .q      (acc_q)
    );

    sacc_shift_reg #(.W(N)) u_addend (
        .clk    (clk),
        .rst    (rst),
        .op     (add_op),
        .par_in (b_in),
        .top_in (add_top),
        .q      (addend_q)
    );

    always_ff @(posedge clk) begin
        if (rst)
            carry_q <= 1'b0;
        else if (accept)
            carry_q <= 1'b0;
        else if (busy)
            carry_q <= fa.cout;
    end

    assign result    = acc_q;
    assign carry_out = carry_q;

    // R6
    carry_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !carry_out);
    // R10
    carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(carry_out));
    // R2
    acc_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load_a) |=> $stable(result));
    // R2
    acc_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && load_a) |=> (result == $past(a_in)));
endmodule

// File: tb/serial_acc_adder_tb_top.sv
module serial_acc_adder_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         load_a, load_b, b_src, ser_in, start;
    logic [N-1:0] a_in, b_in;
    logic         busy, done, carry_out;
    logic [N-1:0] result;

    int checks = 0;
    int errors = 0;
    int busy_cnt = 0;

    logic [N:0]   exp_q[$];
    string        tag_q[$];
    logic [N-1:0] acc, bval;
    logic [N:0]   mon_e;
    string        mon_t;

    always #10 clk = ~clk;

    serial_acc_adder #(.N(N)) dut_i (
        .clk(clk), .rst(rst), .load_a(load_a), .a_in(a_in),
        .load_b(load_b), .b_in(b_in), .b_src(b_src), .ser_in(ser_in),
        .start(start), .busy(busy), .done(done), .result(result),
        .carry_out(carry_out)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Monitor: counts shift cycles and pops expected totals on done
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                chk(busy_cnt == N, "R3", "shift cycle count", busy_cnt, N);
                chk(!busy, "R3", "busy low with done", busy, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected done", 1, 0);
                end else begin
                    mon_e = exp_q.pop_front();
                    mon_t = tag_q.pop_front();
                    chk(result == mon_e[N-1:0], mon_t, "result", result, mon_e[N-1:0]);
                    chk(carry_out == mon_e[N], mon_t, "carry_out", carry_out, mon_e[N]);
                end
                busy_cnt = 0;
            end
        end
    end

    // Driver: called at a negedge; returns at the negedge where done shows
    task automatic run(input string tag, input bit ser, input logic [N-1:0] v,
                       input bit disturb, input bit ld_a, input logic [N-1:0] av,
                       input bit ld_b, input logic [N-1:0] bv);
        logic [N:0] sum;
        if (ld_a) begin acc = av; a_in = av; load_a = 1'b1; end
        if (ld_b) begin bval = bv; b_in = bv; load_b = 1'b1; end
        sum = {1'b0, acc} + {1'b0, bval};
        exp_q.push_back(sum);
        tag_q.push_back(tag);
        acc = sum[N-1:0];
        if (ser) bval = v;
        b_src = ser;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; load_a = 1'b0; load_b = 1'b0;
        for (int i = 0; i < N; i++) begin
            ser_in = v[i];
            if (disturb && i == 2) begin
                load_a = 1'b1; a_in = '1;
                load_b = 1'b1; b_in = '1;
                start = 1'b1;
            end
            @(negedge clk);
            load_a = 1'b0; load_b = 1'b0; start = 1'b0;
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; load_a = 0; load_b = 0; b_src = 0; ser_in = 0; start = 0;
        a_in = '0; b_in = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(result == 0, "R1", "result", result, 0);
        chk(carry_out == 0, "R1", "carry_out", carry_out, 0);
        chk(!busy && !done, "R1", "busy/done", {busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);

        // R2 idle parallel loads
        load_a = 1; a_in = 8'h5A; load_b = 1; b_in = 8'h11;
        @(negedge clk);
        load_a = 0; load_b = 0;
        chk(result == 8'h5A, "R2", "load_a", result, 8'h5A);
        load_b = 1; b_in = 8'h3C;
        @(negedge clk);
        load_b = 0;
        chk(result == 8'h5A, "R2", "A after lone load_b", result, 8'h5A);
        chk(carry_out == 0, "R2", "carry after lone load_b", carry_out, 0);
        acc = 8'h5A; bval = 8'h3C;

        run("R4", 0, '0, 0, 0, '0, 0, '0);          // 5A+3C = 96
        run("R5", 0, '0, 0, 0, '0, 0, '0);          // 96+3C = D2
        run("R5", 0, '0, 0, 0, '0, 0, '0);          // D2+3C = 10E

        // R10 carry_out and result hold while idle
        repeat (3) @(negedge clk);
        chk(carry_out == 1'b1, "R10", "carry_out held", carry_out, 1);
        chk(result == 8'h0E, "R10", "result held", result, 8'h0E);

        run("R6", 0, '0, 0, 0, '0, 1, 8'h01);       // 0E+01 = 0F, carry cleared
        run("R8", 1, 8'hA5, 0, 1, 8'hFF, 1, 8'h01); // FF+01 = 100, B <- A5
        run("R8", 0, '0, 0, 0, '0, 0, '0);          // 00+A5 = A5
        run("R9", 0, '0, 0, 1, 8'h80, 1, 8'h80);    // load+start: 100
        run("R10", 0, '0, 0, 0, '0, 0, '0);         // start with done: 00+80
        run("R7", 0, '0, 1, 0, '0, 0, '0);          // 80+80, disturbances ignored

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3", "pending results", exp_q.size(), 0);
        chk(!busy, "R7", "no extra pass started", busy, 0);
        summary();
        $finish;
    end
endmodule